// File: doc/BRIEF.md
# Hierarchical Page Table Walker

This block turns a virtual address into a physical address by walking a page table tree of several levels held in ordinary memory. A translation request carries the virtual address, a write flag and a user-mode flag. The walker latches them together with the table root address of the current process. It then reads one table entry per level through a single-read memory port. Each valid entry at an upper level names the frame that holds the next table. The entry at the last level names the data frame, and its permission bits are checked against the access.

The result is reported in a one-cycle response. The response carries the physical address, a fault code, and the level at which the walk stopped. A walk ends at the first invalid entry with a missing-page fault. It ends at the leaf with a permission fault when the access is not allowed. Only one walk is in flight at a time, and the request side stays closed until that walk has reported. The number of levels, the index width per level, the page offset width and the address and entry widths are parameters. The defaults are two levels of 10 index bits, 4 KB pages, a 32-bit physical address and 8-byte entries.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, and both `resp_valid` and `mem_req_valid` are 0.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both 1. From the next cycle, `req_ready` stays 0 through the cycle in which `resp_valid` is 1, and it returns to 1 in the cycle after that. A request presented while `req_ready` is 0 is ignored and causes no memory read.
- R3: The first read of a walk goes to the root address on `ptbr` as sampled when the request was taken, plus the top index field of the virtual address times 8. The index fields split the bits above the page offset, and the most significant field belongs to the first level. A later change of `ptbr` does not affect a walk already in progress.
- R4: An entry is 64 bits wide. Bit 0 is valid, bit 1 allows reads, bit 2 allows writes and bit 3 marks a supervisor-only page. Bits [31:12] hold a frame number. Each lower-level read goes to the frame number of the previous entry shifted left by 12, plus that level's index field times 8.
- R5: When the last-level entry is valid and allowed, the response carries `resp_fault` = 0 and `resp_level` = LEVELS. `resp_pa` is that entry's frame number followed by the unchanged page offset.
- R6: An entry with bit 0 clear, at any level, ends the walk with `resp_fault` = 1. `resp_level` is the 1-based level of that entry, `resp_pa` is 0, and no further memory read is issued.
- R7: At the last level, a valid entry ends the walk with `resp_fault` = 2, `resp_pa` = 0 and `resp_level` = LEVELS when any of three cases holds. The cases are a user-mode access to a supervisor page, a write to a page without write permission, and a read of a page without read permission. A supervisor-mode access to a supervisor page is allowed. The fault code 3 never appears.
- R8: `mem_req_valid` stays 1 with `mem_req_addr` unchanged until `mem_req_ready` is 1. At most one read is outstanding. The walk waits for `mem_rsp_valid` for any number of cycles.
- R9: `resp_valid` is 1 for exactly one cycle per accepted request and never at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | LEVELS*IDX_W+OFF_W | Virtual address to translate |
| req_write | input | 1 | Access is a write (0 means read) |
| req_user | input | 1 | Access comes from user mode |
| ptbr | input | PA_W | Root table address of the current process |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_pa | output | PA_W | Translated physical address, 0 on a fault |
| resp_fault | output | 2 | 0 none, 1 missing page, 2 permission |
| resp_level | output | $clog2(LEVELS+1) | 1-based level at which the walk ended |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | PTE_W | Entry contents |

## Verification
The bench aims at an invalid entry at each level. A walker that failed to stop at the first level would issue a second read and be caught by the read-order model; one that reported the wrong depth would be caught by the level check. An entry that has its permission bits set but its valid bit clear must still fault, which catches a design that tests the wrong bit. Each permission case, including a supervisor access to a supervisor page, is run, along with the all-ones index and offset corner. The bench also changes the root address mid-walk, holds `req_valid` high during a walk, and runs the memory with stalls and slow responses. This exposes a walker that reads the root address too late, accepts a second request, or drops its read while not granted.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PAGE = 2'd1,
    FLT_PROT = 2'd2
  } walk_fault_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ISSUE,
    S_WAIT,
    S_DONE
  } walk_state_e;

  localparam int unsigned ENT_VALID = 0;
  localparam int unsigned ENT_READ  = 1;
  localparam int unsigned ENT_WRITE = 2;
  localparam int unsigned ENT_SUPER = 3;
  localparam int unsigned ENT_FLAGS = 4;

  // Permission rule for a leaf entry; returns 1 when the access must fault.
  function automatic logic perm_denied(input logic rd_ok, input logic wr_ok,
                                       input logic super_pg, input logic is_write,
                                       input logic is_user);
    return (is_user && super_pg) || (is_write && !wr_ok) || (!is_write && !rd_ok);
  endfunction

endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int unsigned LEVELS = 2,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned PTE_W  = 64
) (
  input  logic [LEVELS*IDX_W+OFF_W-1:0]          va,
  input  logic [((LEVELS>1)?$clog2(LEVELS):1)-1:0] level,
  input  logic [PA_W-1:0]                        table_base,
  output logic [PA_W-1:0]                        entry_addr
);
  localparam int unsigned ESZ_LOG2 = $clog2(PTE_W / 8);

  logic [IDX_W-1:0] field [LEVELS];
  logic [IDX_W-1:0] sel_field;

  // Level 0 takes the most significant index field.
  for (genvar g = 0; g < LEVELS; g++) begin : g_field
    assign field[g] = va[OFF_W + (LEVELS - 1 - g) * IDX_W +: IDX_W];
  end

  always_comb begin
    sel_field = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (int'(level) == l) sel_field = field[l];
    end
  end

  function automatic logic [PA_W-1:0] index_offset(input logic [IDX_W-1:0] idx);
    return PA_W'(idx) << ESZ_LOG2;
  endfunction

  assign entry_addr = table_base + index_offset(sel_field);

endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check
  import pt_walker_pkg::*;
(
  input  logic entry_read,
  input  logic entry_write,
  input  logic entry_super,
  input  logic is_write,
  input  logic is_user,
  output logic violation
);
  logic deny_super;
  logic deny_write;
  logic deny_read;

  assign deny_super = is_user && entry_super;
  assign deny_write = is_write && !entry_write;
  assign deny_read  = !is_write && !entry_read;

  assign violation = perm_denied(entry_read, entry_write, entry_super, is_write, is_user)
                     && (deny_super || deny_write || deny_read);

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned LEVELS = 2,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned PTE_W  = 64
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  output logic                               req_ready,
  input  logic [LEVELS*IDX_W+OFF_W-1:0]      req_va,
  input  logic                               req_write,
  input  logic                               req_user,
  input  logic [PA_W-1:0]                    ptbr,
  output logic                               resp_valid,
  output logic [PA_W-1:0]                    resp_pa,
  output logic [1:0]                         resp_fault,
  output logic [$clog2(LEVELS+1)-1:0]        resp_level,
  output logic                               mem_req_valid,
  input  logic                               mem_req_ready,
  output logic [PA_W-1:0]                    mem_req_addr,
  input  logic                               mem_rsp_valid,
  input  logic [PTE_W-1:0]                   mem_rsp_data
);
  localparam int unsigned VA_W   = LEVELS * IDX_W + OFF_W;
  localparam int unsigned PPN_W  = PA_W - OFF_W;
  localparam int unsigned LVL_IW = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int unsigned LVL_OW = $clog2(LEVELS + 1);

  walk_state_e         state_q;
  logic [VA_W-1:0]     va_q;
  logic                wr_q;
  logic                usr_q;
  logic [PA_W-1:0]     base_q;
  logic [LVL_IW-1:0]   lvl_q;
  logic [PA_W-1:0]     pa_q;
  walk_fault_e         fault_q;
  logic [LVL_OW-1:0]   level_q;

  // Named internal events
  logic              ev_accept;
  logic              ev_mem_fire;
  logic              ev_rsp_take;
  logic              ev_page_fault;
  logic              ev_descend;
  logic              ev_leaf;
  logic              ev_prot;
  logic              ent_valid;
  logic              at_leaf;
  logic              prot_bad;
  logic [PPN_W-1:0]  ent_frame;
  logic [LVL_OW-1:0] lvl_report;
  logic              unused_ent_bits;

  assign req_ready     = (state_q == S_IDLE);
  assign resp_valid    = (state_q == S_DONE);
  assign mem_req_valid = (state_q == S_ISSUE);

  assign ev_accept     = req_valid && req_ready;
  assign ev_mem_fire   = mem_req_valid && mem_req_ready;
  assign ev_rsp_take   = (state_q == S_WAIT) && mem_rsp_valid;
  assign ent_valid     = mem_rsp_data[ENT_VALID];
  assign at_leaf       = (lvl_q == LVL_IW'(LEVELS - 1));
  assign ent_frame     = mem_rsp_data[OFF_W +: PPN_W];
  assign ev_page_fault = ev_rsp_take && !ent_valid;
  assign ev_descend    = ev_rsp_take && ent_valid && !at_leaf;
  assign ev_leaf       = ev_rsp_take && ent_valid && at_leaf;
  assign ev_prot       = ev_leaf && prot_bad;
  assign lvl_report    = LVL_OW'(lvl_q) + LVL_OW'(1);
  assign unused_ent_bits = ^(mem_rsp_data >> PA_W) ^ ^mem_rsp_data[OFF_W-1:ENT_FLAGS];

  pt_entry_addr #(
    .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W), .PTE_W(PTE_W)
  ) u_addr (
    .va         (va_q),
    .level      (lvl_q),
    .table_base (base_q),
    .entry_addr (mem_req_addr)
  );

  pt_perm_check u_perm (
    .entry_read  (mem_rsp_data[ENT_READ]),
    .entry_write (mem_rsp_data[ENT_WRITE]),
    .entry_super (mem_rsp_data[ENT_SUPER]),
    .is_write    (wr_q),
    .is_user     (usr_q),
    .violation   (prot_bad)
  );

  function automatic logic [PA_W-1:0] frame_to_addr(input logic [PPN_W-1:0] fr,
                                                    input logic [OFF_W-1:0] off);
    return {fr, off};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      base_q  <= '0;
      lvl_q   <= '0;
      pa_q    <= '0;
      fault_q <= FLT_NONE;
      level_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (ev_accept) begin
            va_q    <= req_va;
            wr_q    <= req_write;
            usr_q   <= req_user;
            base_q  <= ptbr;
            lvl_q   <= '0;
            state_q <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          if (ev_mem_fire) state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (ev_page_fault) begin
            pa_q    <= '0;
            fault_q <= FLT_PAGE;
            level_q <= lvl_report;
            state_q <= S_DONE;
          end else if (ev_descend) begin
            base_q  <= frame_to_addr(ent_frame, '0);
            lvl_q   <= lvl_q + LVL_IW'(1);
            state_q <= S_ISSUE;
          end else if (ev_leaf) begin
            pa_q    <= ev_prot ? '0 : frame_to_addr(ent_frame, va_q[OFF_W-1:0]);
            fault_q <= ev_prot ? FLT_PROT : FLT_NONE;
            level_q <= lvl_report;
            state_q <= S_DONE;
          end
        end
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign resp_pa    = pa_q;
  assign resp_fault = fault_q;
  assign resp_level = level_q;

  // Assertions
  a_r2_closed_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !req_ready);
  a_r2_closed_on_result: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  a_r8_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mem_fire |=> !mem_req_valid);
  a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault == FLT_NONE) |-> resp_pa[OFF_W-1:0] == va_q[OFF_W-1:0]);
  a_r5_full_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault == FLT_NONE) |-> resp_level == LVL_OW'(LEVELS));
  a_r6_no_address_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault != FLT_NONE) |-> resp_pa == '0);
  a_r6_stop_after_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    ev_page_fault |=> !mem_req_valid);
  a_r7_prot_at_leaf: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault == FLT_PROT) |-> resp_level == LVL_OW'(LEVELS));
  a_r7_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> resp_fault != 2'd3);
  a_r6_level_range: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_level >= LVL_OW'(1) && resp_level <= LVL_OW'(LEVELS)));

endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  localparam int CLK_PERIOD = 10;
  localparam int LEVELS = 2;
  localparam int IDX_W  = 10;
  localparam int OFF_W  = 12;
  localparam int PA_W   = 32;
  localparam int PTE_W  = 64;
  localparam int VA_W   = LEVELS * IDX_W + OFF_W;
  localparam int LVL_OW = $clog2(LEVELS + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [VA_W-1:0]   req_va = '0;
  logic              req_write = 1'b0;
  logic              req_user = 1'b0;
  logic [PA_W-1:0]   ptbr = 32'h0010_0000;
  logic              resp_valid;
  logic [PA_W-1:0]   resp_pa;
  logic [1:0]        resp_fault;
  logic [LVL_OW-1:0] resp_level;
  logic              mem_req_valid;
  logic              mem_req_ready;
  logic [PA_W-1:0]   mem_req_addr;
  logic              mem_rsp_valid;
  logic [PTE_W-1:0]  mem_rsp_data;

  pt_walker #(.LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W), .PTE_W(PTE_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_write(req_write), .req_user(req_user), .ptbr(ptbr),
    .resp_valid(resp_valid), .resp_pa(resp_pa), .resp_fault(resp_fault), .resp_level(resp_level),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Table memory model
  logic [63:0] tbl [logic [31:0]];
  logic [31:0] exp_q [$];

  function automatic logic [63:0] rd(input logic [31:0] a);
    return tbl.exists(a) ? tbl[a] : 64'h0;
  endfunction

  function automatic logic [31:0] mkva(input int i1, input int i2, input int off);
    return (32'(i1) << 22) | (32'(i2) << 12) | 32'(off);
  endfunction

  // Behavioural reference walk
  task automatic model(input logic [31:0] va, input bit w, input bit u,
                       output logic [31:0] pa, output logic [1:0] f, output int lv);
    logic [31:0] base;
    base = ptbr; pa = 0; f = 0; lv = LEVELS;
    for (int l = 0; l < LEVELS; l++) begin
      int idx;
      logic [31:0] a;
      logic [63:0] e;
      idx = int'((va >> (OFF_W + IDX_W * (LEVELS - 1 - l))) & ((1 << IDX_W) - 1));
      a = base + 32'(idx * 8);
      exp_q.push_back(a);
      e = rd(a);
      if (e[0] == 1'b0) begin f = 1; lv = l + 1; return; end
      if (l < LEVELS - 1) begin
        base = {e[31:12], 12'h000};
      end else if ((u && e[3]) || (w && !e[2]) || (!w && !e[1])) begin
        f = 2;
      end else begin
        pa = {e[31:12], va[11:0]};
      end
    end
  endtask

  // Memory responder
  bit stall_mode = 1'b0;
  int lat = 0;
  initial begin
    int cyc = 0;
    bit pend = 0;
    int cnt = 0;
    logic [63:0] pdata = 0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (cnt == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = pdata; pend = 0; end
        else cnt--;
      end
      mem_req_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 R6 unexpected extra read", 64'(mem_req_addr), 64'h0);
        else begin
          logic [31:0] ea;
          ea = exp_q.pop_front();
          chk(mem_req_addr == ea, "R3 R4 entry address", 64'(mem_req_addr), 64'(ea));
        end
        pend = 1; cnt = lat; pdata = rd(mem_req_addr);
      end
    end
  end

  // Cycle model of the request side, compared every clock
  bit mon_on = 1'b0;
  initial begin
    bit busy = 0;
    bit prev_resp = 0;
    forever begin
      @(negedge clk); #1;
      if (mon_on) begin
        chk(req_ready == !busy, "R2 ready follows walk", 64'(req_ready), 64'(!busy));
        chk(!(prev_resp && resp_valid), "R9 one-cycle result", 64'(resp_valid), 64'h0);
        if (resp_valid) chk(busy, "R9 result only for a taken request", 64'(resp_valid), 64'h0);
        prev_resp = resp_valid;
        if (req_valid && req_ready) busy = 1;
        else if (resp_valid) busy = 0;
      end
    end
  end

  logic [31:0] e_pa;
  logic [1:0]  e_f;
  int          e_lv;

  task automatic start(input logic [31:0] va, input bit w, input bit u);
    do @(negedge clk); while (!req_ready);
    model(va, w, u, e_pa, e_f, e_lv);
    req_va = va; req_write = w; req_user = u; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish(input string tag);
    do begin @(negedge clk); #1; end while (!resp_valid);
    chk(resp_fault == e_f, {tag, " fault code"}, 64'(resp_fault), 64'(e_f));
    chk(resp_pa == e_pa, {tag, " physical address"}, 64'(resp_pa), 64'(e_pa));
    chk(int'(resp_level) == e_lv, {tag, " level"}, 64'(resp_level), 64'(e_lv));
    chk(exp_q.size() == 0, {tag, " R8 all reads issued"}, 64'(exp_q.size()), 64'h0);
  endtask

  task automatic walk(input logic [31:0] va, input bit w, input bit u, input string tag);
    start(va, w, u);
    finish(tag);
  endtask

  initial begin
    // Tables: root at 0x0010_0000, flags V=1 R=2 W=4 S=8
    tbl[32'h0010_0000 + 0 * 8]    = 64'h0020_0000 | 64'h1;
    tbl[32'h0010_0000 + 1023 * 8] = 64'h0030_0000 | 64'h1;
    tbl[32'h0010_0000 + 5 * 8]    = 64'h0040_0006;
    tbl[32'h0020_0000 + 0 * 8]    = 64'h0ABC_D000 | 64'h3;
    tbl[32'h0020_0000 + 1 * 8]    = 64'h0123_4000 | 64'h7;
    tbl[32'h0020_0000 + 2 * 8]    = 64'h0555_5000 | 64'hF;
    tbl[32'h0020_0000 + 3 * 8]    = 64'h0F0F_0000 | 64'h6;
    tbl[32'h0020_0000 + 4 * 8]    = 64'h0777_7000 | 64'h5;
    tbl[32'h0030_0000 + 1023 * 8] = 64'hFFFF_F000 | 64'h7;
    tbl[32'h0050_0000]            = 64'h0999_9000 | 64'h7;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready in reset", 64'(req_ready), 64'h1);
    chk(resp_valid == 1'b0, "R1 no result in reset", 64'(resp_valid), 64'h0);
    chk(mem_req_valid == 1'b0, "R1 no read in reset", 64'(mem_req_valid), 64'h0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready && !resp_valid && !mem_req_valid, "R1 idle after reset",
        64'({req_ready, resp_valid, mem_req_valid}), 64'h4);
    mon_on = 1'b1;

    walk(mkva(0, 0, 12'h123), 0, 1, "R5 user read");
    walk(mkva(0, 0, 12'h7FF), 1, 1, "R7 write to read-only");
    walk(mkva(0, 1, 12'hFFF), 1, 1, "R5 user write");
    walk(mkva(0, 2, 12'h010), 0, 1, "R7 user to supervisor page");
    walk(mkva(0, 2, 12'h010), 1, 0, "R7 supervisor on supervisor page");
    walk(mkva(5, 0, 0), 0, 0, "R6 invalid at level 1");
    walk(mkva(0, 3, 12'h040), 0, 0, "R6 flags without valid at level 2");
    walk(mkva(0, 7, 12'h001), 1, 0, "R6 empty entry at level 2");
    walk(mkva(0, 4, 0), 0, 0, "R7 read of write-only page");
    walk(mkva(0, 4, 12'h888), 1, 0, "R5 write to write-only page");
    walk(mkva(1023, 1023, 12'hFFF), 0, 1, "R5 all-ones index and offset");
    walk(mkva(0, 0, 0), 0, 0, "R5 zero address");

    // R3: root change during a walk has no effect
    start(mkva(0, 1, 12'h321), 0, 1);
    ptbr = 32'h0050_0000;
    finish("R3 root latched at accept");
    ptbr = 32'h0010_0000;

    // R2: a request held during a walk is ignored
    start(mkva(0, 1, 12'h456), 0, 0);
    req_va = mkva(1023, 1023, 0); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    finish("R2 request during walk ignored");

    // R8: stalled and slow memory
    stall_mode = 1'b1; lat = 3;
    walk(mkva(0, 0, 12'hABC), 0, 1, "R8 slow memory user read");
    walk(mkva(5, 9, 0), 0, 1, "R8 slow memory invalid root entry");
    walk(mkva(1023, 1023, 12'h5A5), 1, 0, "R8 slow memory write");
    walk(mkva(0, 2, 0), 1, 1, "R8 slow memory supervisor page");
    lat = 0;
    walk(mkva(0, 1, 12'h002), 1, 1, "R8 stalled ready");
    stall_mode = 1'b0;

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule